// File: doc/BRIEF.md
# Ring Buffer Burst Writer for Packet Streams

This block takes a ready/valid word stream, where an end flag marks the final word of each packet, and stores it into a circular window of memory through a split write port. One channel carries the start address and beat count of a burst. A second channel carries the data words, and a flag marks the final beat of the burst. Incoming words collect in a small local store. A burst goes out when the store holds the longest permitted burst, or earlier when a packet ends, so a packet's tail is never held back waiting for words that may never come.

Only one burst is active at a time. While the address and data phases run, the input is stalled. Each burst starts at a word-aligned address. The next burst starts just after it. When the next address would reach the top of the window, it returns to the window base. A burst never runs past the top of the window: the group being collected is closed early at the wrap point. An output pointer holds the address just past the last fully written packet, so a consumer knows how far the data is complete.

Top module: `stream_ring_burst_writer`

## Requirements
- R1: After reset, s_ready is 1, aw_valid and w_valid are 0, and done_addr equals the window base.
- R2: s_ready is 1 exactly while words are being collected. It is 0 from the cycle after a group closes until the cycle after that group's final data beat is accepted. At most one of s_ready, aw_valid and w_valid is 1 in any cycle.
- R3: When the collected group reaches the burst limit, the group closes and aw_valid rises in the next cycle. The burst limit is the lesser of MAX_BURST (16) and the number of words left before the window top.
- R4: An accepted word with s_last set closes the group at once, whatever its size (1 word or more). Every accepted word is later sent on the data channel.
- R5: While aw_valid is 1, aw_addr is the burst start address and aw_len is the beat count minus one. Both, and aw_valid itself, hold steady until aw_ready is seen.
- R6: Data beats carry the group's words in arrival order. w_last is 1 only on the final beat. A beat stays steady until w_ready is seen.
- R7: The next burst address is the previous start plus beats times DATA_W/8 bytes. It becomes the window base when it reaches base + RING_WORDS*DATA_W/8.
- R8: No burst extends past the window top: start + (aw_len+1)*DATA_W/8 never exceeds it.
- R9: done_addr changes only in the cycle after the final beat of a burst whose last word had s_last set. It then equals that burst's next address.
- R10: aw_valid and w_valid come from registers. Changing aw_ready or w_ready within a cycle does not change them in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input word present |
| s_ready | output | 1 | Block takes the input word this cycle |
| s_data | input | DATA_W | Input word |
| s_last | input | 1 | Input word ends a packet |
| aw_valid | output | 1 | Burst address offered |
| aw_ready | input | 1 | Memory takes the burst address |
| aw_addr | output | ADDR_W | Burst start byte address |
| aw_len | output | clog2(MAX_BURST) | Beats in burst minus one |
| w_valid | output | 1 | Data beat offered |
| w_ready | input | 1 | Memory takes the data beat |
| w_data | output | DATA_W | Data beat |
| w_last | output | 1 | Final beat of the burst |
| done_addr | output | ADDR_W | Address just past the last completed packet |

## Verification
A wrong fill count shows up in the next cycle as an early or late aw_valid, or as a wrong aw_len. A wrong beat index shows up at once as a wrong w_data or a misplaced w_last. A wrong address register is exposed on the next burst's aw_addr, and at wrap time as a burst running past the window top. A stale packet pointer is visible on done_addr in the cycle after the flushing beat. The reference model is compared on every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/srbw_pkg.sv
package srbw_pkg;

  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // number of whole words between addr and the top of the window
  function automatic logic [63:0] f_words_to_top(input logic [63:0] addr,
                                                 input logic [63:0] top,
                                                 input int unsigned shift);
    return (top - addr) >> shift;
  endfunction

  // largest group that may be collected at this address
  function automatic logic [63:0] f_group_limit(input logic [63:0] words_left,
                                                input logic [63:0] max_burst);
    return (words_left < max_burst) ? words_left : max_burst;
  endfunction

  // start of the following burst, folded back to base at the window top
  function automatic logic [63:0] f_next_start(input logic [63:0] addr,
                                               input logic [63:0] beats,
                                               input int unsigned shift,
                                               input logic [63:0] base,
                                               input logic [63:0] top);
    logic [63:0] nxt;
    nxt = addr + (beats << shift);
    return (nxt >= top) ? base : nxt;
  endfunction

endpackage

// File: rtl/srbw_word_buf.sv
module srbw_word_buf #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) slot_q[i] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/srbw_ring_ptr.sv
module srbw_ring_ptr #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned MAX_BURST = 16,
  parameter int unsigned WB_SHIFT  = 2,
  parameter logic [63:0] BASE64    = 64'h1000,
  parameter logic [63:0] TOP64     = 64'h10a0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [CNT_W-1:0]  adv_beats,
  input  logic              adv_pkt_end,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  limit,
  output logic [ADDR_W-1:0] done_addr
);
  import srbw_pkg::*;

  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] done_q;
  logic [ADDR_W-1:0] next_w;

  assign next_w = ADDR_W'(f_next_start(64'(cur_q), 64'(adv_beats), WB_SHIFT,
                                       BASE64, TOP64));
  assign limit  = CNT_W'(f_group_limit(f_words_to_top(64'(cur_q), TOP64, WB_SHIFT),
                                       64'(MAX_BURST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= ADDR_W'(BASE64);
      done_q <= ADDR_W'(BASE64);
    end else if (adv) begin
      cur_q <= next_w;
      if (adv_pkt_end) done_q <= next_w;
    end
  end

  assign cur_addr  = cur_q;
  assign done_addr = done_q;

  AST_RING_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(cur_q) >= BASE64) && (64'(cur_q) < TOP64)); // R7
  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    limit != '0); // R8
  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cur_q == ADDR_W'(BASE64)) ||
            (64'(cur_q) == 64'($past(cur_q)) + (64'($past(adv_beats)) << WB_SHIFT))); // R7

endmodule

// File: rtl/srbw_burst_fsm.sv
module srbw_burst_fsm #(
  parameter int unsigned MAX_BURST = 16,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_last,
  input  logic             aw_ready,
  input  logic             w_ready,
  input  logic [CNT_W-1:0] limit,
  output logic             s_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             aw_valid,
  output logic [IDX_W-1:0] aw_len,
  output logic             w_valid,
  output logic             w_last,
  output logic [IDX_W-1:0] rd_idx,
  output logic             burst_done,
  output logic [CNT_W-1:0] burst_beats,
  output logic             burst_pkt_end
);
  import srbw_pkg::*;

  phase_e           phase_q;
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] beat_q;
  logic             pkt_q;

  logic             take_w;
  logic [CNT_W-1:0] fill_inc_w;
  logic             close_w;
  logic             final_beat_w;

  assign s_ready      = (phase_q == PH_FILL);
  assign aw_valid     = (phase_q == PH_ADDR);
  assign w_valid      = (phase_q == PH_DATA);
  assign take_w       = s_ready && s_valid;
  assign fill_inc_w   = fill_q + CNT_W'(1);
  assign close_w      = take_w && (s_last || (fill_inc_w == limit));
  assign final_beat_w = (beat_q == (fill_q - CNT_W'(1)));

  assign wr_en         = take_w;
  assign wr_idx        = IDX_W'(fill_q);
  assign rd_idx        = IDX_W'(beat_q);
  assign aw_len        = IDX_W'(fill_q - CNT_W'(1));
  assign w_last        = w_valid && final_beat_w;
  assign burst_done    = w_valid && w_ready && final_beat_w;
  assign burst_beats   = fill_q;
  assign burst_pkt_end = pkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      fill_q  <= '0;
      beat_q  <= '0;
      pkt_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_FILL: begin
          if (take_w) begin
            fill_q <= fill_inc_w;
            pkt_q  <= s_last;
          end
          if (close_w) phase_q <= PH_ADDR;
        end
        PH_ADDR: begin
          if (aw_ready) begin
            phase_q <= PH_DATA;
            beat_q  <= '0;
          end
        end
        PH_DATA: begin
          if (w_ready) begin
            if (final_beat_w) begin
              phase_q <= PH_FILL;
              fill_q  <= '0;
            end else begin
              beat_q <= beat_q + CNT_W'(1);
            end
          end
        end
        default: phase_q <= PH_FILL;
      endcase
    end
  end

  AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_ready, aw_valid, w_valid})); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= limit); // R8
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_len)); // R5
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(rd_idx) && $stable(w_last)); // R6
  AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> fill_q != '0); // R3
  AST_RESUME_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> s_ready && (fill_q == '0)); // R2
  AST_FLUSH_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_w && s_last |=> aw_valid); // R4

endmodule

// File: rtl/stream_ring_burst_writer.sv
module stream_ring_burst_writer #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MAX_BURST  = 16,
  parameter int unsigned RING_BASE  = 32'h0000_1000,
  parameter int unsigned RING_WORDS = 40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [DATA_W-1:0]            s_data,
  input  logic                         s_last,
  output logic                         aw_valid,
  input  logic                         aw_ready,
  output logic [ADDR_W-1:0]            aw_addr,
  output logic [$clog2(MAX_BURST)-1:0] aw_len,
  output logic                         w_valid,
  input  logic                         w_ready,
  output logic [DATA_W-1:0]            w_data,
  output logic                         w_last,
  output logic [ADDR_W-1:0]            done_addr
);

  localparam int unsigned IDX_W    = $clog2(MAX_BURST);
  localparam int unsigned CNT_W    = $clog2(MAX_BURST + 1);
  localparam int unsigned WB_SHIFT = $clog2(DATA_W / 8);
  localparam logic [63:0] BASE64   = 64'(RING_BASE);
  localparam logic [63:0] TOP64    = BASE64 + (64'(RING_WORDS) << WB_SHIFT);

  // named internal events shared between the pieces
  logic             wr_en_w;
  logic [IDX_W-1:0] wr_idx_w;
  logic [IDX_W-1:0] rd_idx_w;
  logic [CNT_W-1:0] limit_w;
  logic             burst_done_w;
  logic [CNT_W-1:0] burst_beats_w;
  logic             burst_pkt_w;

  srbw_burst_fsm #(
    .MAX_BURST(MAX_BURST),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_valid      (s_valid),
    .s_last       (s_last),
    .aw_ready     (aw_ready),
    .w_ready      (w_ready),
    .limit        (limit_w),
    .s_ready      (s_ready),
    .wr_en        (wr_en_w),
    .wr_idx       (wr_idx_w),
    .aw_valid     (aw_valid),
    .aw_len       (aw_len),
    .w_valid      (w_valid),
    .w_last       (w_last),
    .rd_idx       (rd_idx_w),
    .burst_done   (burst_done_w),
    .burst_beats  (burst_beats_w),
    .burst_pkt_end(burst_pkt_w)
  );

  srbw_word_buf #(
    .DATA_W(DATA_W),
    .DEPTH (MAX_BURST),
    .IDX_W (IDX_W)
  ) i_buf (
    .clk    (clk),
    .wr_en  (wr_en_w),
    .wr_idx (wr_idx_w),
    .wr_data(s_data),
    .rd_idx (rd_idx_w),
    .rd_data(w_data)
  );

  srbw_ring_ptr #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MAX_BURST(MAX_BURST),
    .WB_SHIFT (WB_SHIFT),
    .BASE64   (BASE64),
    .TOP64    (TOP64)
  ) i_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (burst_done_w),
    .adv_beats  (burst_beats_w),
    .adv_pkt_end(burst_pkt_w),
    .cur_addr   (aw_addr),
    .limit      (limit_w),
    .done_addr  (done_addr)
  );

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (64'(aw_addr) + ((64'(aw_len) + 64'd1) << WB_SHIFT)) <= TOP64); // R8
  AST_AW_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> $stable(aw_addr)); // R5
  AST_DONE_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(done_addr) |-> $past(burst_done_w && burst_pkt_w)); // R9
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> ((64'(aw_addr) - BASE64) & ((64'd1 << WB_SHIFT) - 64'd1)) == 64'd0); // R7

endmodule

// File: tb/test_stream_ring_burst_writer.sv
module test_stream_ring_burst_writer;

  localparam int          WB   = 4;
  localparam longint      BASE = 64'h1000;
  localparam longint      TOP  = BASE + 40 * WB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, aw_ready = 1'b0, w_ready = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, aw_valid, w_valid, w_last;
  logic [31:0] aw_addr, w_data, done_addr;
  logic [3:0]  aw_len;

  stream_ring_burst_writer i_stream_ring_burst_writer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_addr(aw_addr), .aw_len(aw_len), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .w_last(w_last), .done_addr(done_addr)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model
  int          m_phase = 0;      // 0 collect, 1 address, 2 data
  logic [31:0] m_q[$];
  bit          m_pkt = 0;
  int          m_beat = 0;
  longint      m_addr = BASE;
  longint      m_done = BASE;
  int          n_in = 0, n_out = 0;
  logic [31:0] next_word = 32'hA000_0000;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic int m_limit();
    longint left = (TOP - m_addr) / WB;
    return (left < 16) ? int'(left) : 16;
  endfunction

  // compare all outputs against the model, after the readies were driven
  task automatic compare();
    chk("R2 s_ready", s_ready, m_phase == 0);
    chk("R10 aw_valid", aw_valid, m_phase == 1);
    chk("R10 w_valid", w_valid, m_phase == 2);
    chk("R9 done_addr", done_addr, m_done);
    if (m_phase == 1) begin
      chk("R5 aw_addr", aw_addr, m_addr);
      chk("R5 aw_len", aw_len, m_q.size() - 1);
      chk("R8 no cross", (m_addr + m_q.size() * WB) <= TOP, 1);
    end
    if (m_phase == 2) begin
      chk("R6 w_data", w_data, m_q[m_beat]);
      chk("R6 w_last", w_last, m_beat == m_q.size() - 1);
    end
  endtask

  task automatic step_model();
    case (m_phase)
      0: if (s_valid) begin
           m_q.push_back(s_data);
           n_in++;
           m_pkt = s_last;
           if (s_last || m_q.size() == m_limit()) m_phase = 1;
         end
      1: if (aw_ready) begin m_phase = 2; m_beat = 0; end
      default: if (w_ready) begin
           n_out++;
           if (m_beat == m_q.size() - 1) begin
             m_addr = m_addr + m_q.size() * WB;
             if (m_addr >= TOP) m_addr = BASE;
             if (m_pkt) m_done = m_addr;
             m_q.delete();
             m_phase = 0;
           end else m_beat++;
         end
    endcase
  endtask

  task automatic cyc(input bit v, input bit l, input bit ar, input bit wr);
    @(negedge clk);
    s_valid = v; s_last = l; aw_ready = ar; w_ready = wr;
    if (v && m_phase == 0) begin s_data = next_word; end
    else s_data = $urandom;
    #2;
    compare();
    if (v && m_phase == 0) next_word = next_word + 1;
    step_model();
  endtask

  // hand n words to the block, the last with s_last, readies held high
  task automatic send_pkt(input int n);
    int sent = 0;
    while (sent < n) begin
      bit go = (m_phase == 0);
      cyc(1'b1, sent == n - 1, 1'b1, 1'b1);
      if (go) sent++;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && !(m_phase == 0 && m_q.size() == 0); k++)
      cyc(1'b0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 s_ready", s_ready, 1);
    chk("R1 aw_valid", aw_valid, 0);
    chk("R1 w_valid", w_valid, 0);
    chk("R1 done_addr", done_addr, BASE);
    @(negedge clk); rst_n = 1'b1;

    // R3/R7/R8: one 40-word packet, split 16/16/8 at the window top, then wrap
    send_pkt(40);
    drain();
    chk("R7 wrap done_addr", done_addr, BASE);
    chk("R4 all words out", n_out, n_in);

    // R4/R9: short packets flush at once
    send_pkt(3);
    drain();
    chk("R9 done after 3", done_addr, BASE + 3 * WB);
    send_pkt(1);
    drain();
    chk("R9 done after 1", done_addr, BASE + 4 * WB);

    // R5/R6/R10: address and data backpressure
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 40; k++) cyc(1'b1, k == 20, k % 3 == 0, k % 4 == 1);
    drain();

    // mixed traffic with random last, valid and ready patterns
    for (int k = 0; k < 4000; k++)
      cyc(($urandom % 4) != 0, ($urandom % 9) == 0,
          ($urandom % 3) != 0, ($urandom % 3) != 0);

    // close whatever is collecting and drain: nothing may stay stranded (R4)
    while (m_phase != 0) cyc(1'b0, 1'b0, 1'b1, 1'b1);
    send_pkt(1);
    drain();
    chk("R4 no stranded words", n_out, n_in);
    chk("R9 final done", done_addr, m_done);
    chk("R2 idle ready", s_ready, 1);

    finish_run();
  end

endmodule